// File: doc/BRIEF.md
# Selectable Serial Test Pattern Word Generator

This block feeds a serializer under test with one 32-bit parallel word per accepted transfer. The word comes from one of eight sources chosen by a 3-bit select code. Four sources are pseudo-random binary sequences of lengths 7, 15, 23 and 31. The other four are fixed square waves whose half periods are 1, 2, 4 and 20 bits. The stream leaves on a valid/ready interface. Bit 0 of each word is the first bit on the line, and each word continues the serial stream exactly where the previous accepted word stopped.

The back-pressure rules are as follows. A word is consumed only in a cycle where both `out_valid` and `out_ready` are high. While `out_valid` is high and `out_ready` is low, the word is held unchanged. `out_valid` may fall without a transfer only when the stream restarts or `enable` falls. A stream restarts when `enable` rises or when the select code changes while enabled. On a restart every pseudo-random register is reloaded with all ones, every square-wave phase returns to zero, and `out_valid` stays low for exactly that one cycle. The first word of the new stream then appears.

Top module: `pattern_word_gen`

## Requirements
- R1: Select codes 0, 1, 2 and 3 pick the sequences generated by x^7+x^6+1, x^15+x^14+1, x^23+x^18+1 and x^31+x^28+1. Each is a Fibonacci shift register of length L started from all ones. On each step the new bit is the XOR of state bits L-1 and T-1, where T is the lower exponent. That bit is both the output bit and the bit shifted in at position 0. For code 0 the stream repeats every 127 words.
- R2: Each accepted word carries the next 32 stream bits, with the earliest bit in bit 0. The stream is continuous across accepted words.
- R3: Select codes 4, 5, 6 and 7 pick square waves with half periods of 1, 2, 4 and 20 bits. Each starts with its ones half after a restart, so the first words are 0x55555555, 0x33333333, 0x0F0F0F0F and 0x000FFFFF. For code 7 the following words are 0x0FFFFF00 and then 0xFFFF0000.
- R4: In the first cycle with `enable` high after it was low, `out_valid` is low. If the select code does not change, `out_valid` is high in the next cycle and carries the first word of the stream.
- R5: When the select code changes while enabled, `out_valid` is low in that cycle and the new pattern starts from its beginning in the next cycle.
- R6: While `enable` is low, `out_valid` is low.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` holds its value and the stream does not advance.
- R8: During reset and after it, until a restart has completed, `out_valid` is low.
- R9: No pseudo-random shift register ever holds the all-zero state.
- R10: Lowering and then raising `enable` with the same select code restarts that pattern from its first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Stream enable; its rising edge restarts the stream |
| pattern_sel | input | 3 | Pattern code 0..7; a change restarts the stream |
| out_ready | input | 1 | Consumer accepts the word this cycle |
| out_data | output | 32 | Parallel word; bit 0 is sent first |
| out_valid | output | 1 | Word on out_data is valid |

## Verification
The bench builds the block with its default 32-bit word, so every word step moves each shift register 32 positions and steps each square wave across a word boundary. With this width the 40-bit period of the slowest wave is out of step with the word, and its phase pattern repeats only every five words. That misalignment is checked over many words. The 7-bit sequence closes its 127-bit cycle after exactly 127 words, which is within easy reach. Ready toggling and mid-stream select changes are applied to every pattern.

// File: rtl/pgen_pkg.sv
package pgen_pkg;

  localparam int SEL_W    = 3;
  localparam int NUM_PRBS = 4;
  localparam int NUM_SQ   = 4;
  localparam int NUM_SRC  = NUM_PRBS + NUM_SQ;

  typedef enum logic [SEL_W-1:0] {
    PAT_PRBS7  = 3'd0,
    PAT_PRBS15 = 3'd1,
    PAT_PRBS23 = 3'd2,
    PAT_PRBS31 = 3'd3,
    PAT_DIV2   = 3'd4,
    PAT_DIV4   = 3'd5,
    PAT_DIV8   = 3'd6,
    PAT_DIV40  = 3'd7
  } pat_sel_e;

  // Register length of pseudo-random source i.
  function automatic int prbs_len(input int i);
    case (i)
      0:       return 7;
      1:       return 15;
      2:       return 23;
      default: return 31;
    endcase
  endfunction

  // Lower feedback exponent of pseudo-random source i.
  function automatic int prbs_tap(input int i);
    case (i)
      0:       return 6;
      1:       return 14;
      2:       return 18;
      default: return 28;
    endcase
  endfunction

  // Half period in bits of square source i.
  function automatic int sq_half(input int i);
    case (i)
      0:       return 1;
      1:       return 2;
      2:       return 4;
      default: return 20;
    endcase
  endfunction

endpackage

// File: rtl/pgen_lfsr_word.sv
module pgen_lfsr_word #(
  parameter int LEN = 7,
  parameter int TAP = 6,
  parameter int W   = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           advance,
  output logic [W-1:0]   word_o,
  output logic [LEN-1:0] state_o
);

  localparam logic [LEN-1:0] SEED = '1;

  logic [LEN-1:0] state_q;
  logic [LEN-1:0] walk;
  logic [LEN-1:0] state_nxt;
  logic           fb;

  // Unrolled W serial steps; bit k of the word is the k-th bit produced.
  always_comb begin
    walk   = state_q;
    fb     = 1'b0;
    word_o = '0;
    for (int k = 0; k < W; k++) begin
      fb        = walk[LEN-1] ^ walk[TAP-1];
      word_o[k] = fb;
      walk      = {walk[LEN-2:0], fb};
    end
    state_nxt = walk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else if (load || (state_q == '0)) begin
      state_q <= SEED;
    end else if (advance) begin
      state_q <= state_nxt;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/pgen_square_word.sv
module pgen_square_word #(
  parameter int HALF = 1,
  parameter int W    = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         advance,
  output logic [W-1:0] word_o
);

  localparam int PERIOD = 2 * HALF;
  localparam int PW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_nxt;

  // Phase is the stream position of bit 0 modulo the period.
  always_comb begin
    word_o = '0;
    for (int k = 0; k < W; k++) begin
      word_o[k] = (((int'(phase_q) + k) % PERIOD) < HALF);
    end
    phase_nxt = PW'((int'(phase_q) + W) % PERIOD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (load) begin
      phase_q <= '0;
    end else if (advance) begin
      phase_q <= phase_nxt;
    end
  end

endmodule

// File: rtl/pgen_ctrl.sv
module pgen_ctrl
  import pgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             ready,
  output logic             load,
  output logic             fire,
  output logic             valid,
  output logic [SEL_W-1:0] sel_q
);

  logic primed_q;

  always_comb begin
    load  = enable && (!primed_q || (sel_in != sel_q));
    valid = enable && primed_q && (sel_in == sel_q);
    fire  = valid && ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      sel_q    <= '0;
    end else if (!enable) begin
      primed_q <= 1'b0;
    end else if (load) begin
      primed_q <= 1'b1;
      sel_q    <= sel_in;
    end
  end

endmodule

// File: rtl/pattern_word_gen.sv
module pattern_word_gen
  import pgen_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [SEL_W-1:0] pattern_sel,
  input  logic             out_ready,
  output logic [W-1:0]     out_data,
  output logic             out_valid
);

  logic                         load;
  logic                         fire;
  logic [SEL_W-1:0]             sel_q;
  logic [NUM_SRC-1:0][W-1:0]    src_word;
  logic [NUM_SRC-1:0]           src_adv;
  logic [NUM_PRBS-1:0][31:0]    prbs_state;

  pgen_ctrl ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .sel_in (pattern_sel),
    .ready  (out_ready),
    .load   (load),
    .fire   (fire),
    .valid  (out_valid),
    .sel_q  (sel_q)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_adv
    assign src_adv[i] = fire && (sel_q == SEL_W'(i));
  end

  for (genvar g = 0; g < NUM_PRBS; g++) begin : g_prbs
    localparam int LEN = prbs_len(g);
    logic [LEN-1:0] st;
    pgen_lfsr_word #(.LEN(LEN), .TAP(prbs_tap(g)), .W(W)) lfsr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .advance (src_adv[g]),
      .word_o  (src_word[g]),
      .state_o (st)
    );
    assign prbs_state[g] = 32'(st);
  end

  for (genvar g = 0; g < NUM_SQ; g++) begin : g_sq
    pgen_square_word #(.HALF(sq_half(g)), .W(W)) sq_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .advance (src_adv[NUM_PRBS+g]),
      .word_o  (src_word[NUM_PRBS+g])
    );
  end

  assign out_data = src_word[sel_q];

endmodule

// File: rtl/pattern_word_gen_chk.sv
module pattern_word_gen_chk #(
  parameter int W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 enable,
  input logic [2:0]           pattern_sel,
  input logic                 out_ready,
  input logic [W-1:0]         out_data,
  input logic                 out_valid,
  input logic [3:0][31:0]     prbs_state
);

  a_r6_valid_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !out_valid);

  a_r4_rise_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |-> !out_valid);

  a_r4_single_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !out_valid) |=> (!enable || (pattern_sel != $past(pattern_sel)) || out_valid));

  a_r5_sel_change_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && (pattern_sel != $past(pattern_sel))) |-> !out_valid);

  a_r7_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (!enable || (pattern_sel != $past(pattern_sel)) || (out_valid && $stable(out_data))));

  for (genvar g = 0; g < 4; g++) begin : g_nz
    a_r9_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      prbs_state[g] != 32'd0);
  end

endmodule

bind pattern_word_gen pattern_word_gen_chk #(.W(W)) chk_i (.*);

// File: tb/pattern_word_gen_tb_top.sv
module pattern_word_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic [2:0]    pattern_sel = 3'd0;
  logic          out_ready = 1'b0;
  logic [WW-1:0] out_data;
  logic          out_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model state
  int     len_t [4] = '{7, 15, 23, 31};
  int     tap_t [4] = '{6, 14, 18, 28};
  int     half_t[4] = '{1, 2, 4, 20};
  longint rs [4];
  int     rph[4];
  bit     r_primed = 1'b0;
  int     r_sel = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pattern_word_gen dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .pattern_sel (pattern_sel),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_valid   (out_valid)
  );

  function automatic void ref_reseed();
    for (int i = 0; i < 4; i++) begin
      rs[i]  = (64'd1 << len_t[i]) - 1;
      rph[i] = 0;
    end
  endfunction

  // Computes the next word of source sel; commits the advance if adv is set.
  function automatic logic [WW-1:0] ref_word(input int sel, input bit adv);
    logic [WW-1:0] w = '0;
    if (sel < 4) begin
      longint s = rs[sel];
      longint mask = (64'd1 << len_t[sel]) - 1;
      for (int k = 0; k < WW; k++) begin
        longint fb = ((s >> (len_t[sel]-1)) ^ (s >> (tap_t[sel]-1))) & 1;
        w[k] = fb[0];
        s = ((s << 1) | fb) & mask;
      end
      if (adv) rs[sel] = s;
    end else begin
      int h = half_t[sel-4];
      for (int k = 0; k < WW; k++) begin
        w[k] = (((rph[sel-4] + k) % (2*h)) < h);
      end
      if (adv) rph[sel-4] = (rph[sel-4] + WW) % (2*h);
    end
    return w;
  endfunction

  task automatic check_bit(input bit ok, input string tag, input string what,
                           input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One clock: drive inputs, compare with the model, update the model.
  task automatic step(input bit en, input int sel, input bit rdy, input string tag);
    bit exp_v;
    logic [WW-1:0] exp_w;
    enable = en;
    pattern_sel = 3'(sel);
    out_ready = rdy;
    #1;
    exp_v = en && r_primed && (sel == r_sel);
    check_bit(out_valid === exp_v, tag, "valid", WW'(out_valid), WW'(exp_v));
    if (exp_v) begin
      exp_w = ref_word(sel, 1'b0);
      check_bit(out_data === exp_w, tag, "data", out_data, exp_w);
    end
    if (!en) begin
      r_primed = 1'b0;
    end else if (!r_primed || (sel != r_sel)) begin
      r_primed = 1'b1;
      r_sel = sel;
      ref_reseed();
    end else if (exp_v && rdy) begin
      exp_w = ref_word(sel, 1'b1);
    end
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [WW-1:0] w0;
    ref_reseed();
    // R8: valid low during and after reset
    repeat (3) @(negedge clk);
    check_bit(out_valid === 1'b0, "R8", "valid in reset", WW'(out_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);
    step(1'b0, 0, 1'b1, "R8");
    step(1'b0, 0, 1'b1, "R6");

    // R4 / R1: code 0 start and 127-word period
    step(1'b1, 0, 1'b1, "R4");
    w0 = out_data;
    check_bit(out_valid === 1'b1, "R4", "valid after gap", WW'(out_valid), 1);
    for (int i = 0; i < 127; i++) step(1'b1, 0, 1'b1, "R1");
    check_bit(out_data === w0, "R1", "period 127 words", out_data, w0);

    // R3: fixed patterns first words
    step(1'b1, 4, 1'b1, "R5");
    check_bit(out_data === 32'h55555555, "R3", "div2 word", out_data, 32'h55555555);
    step(1'b1, 5, 1'b1, "R5");
    check_bit(out_data === 32'h33333333, "R3", "div4 word", out_data, 32'h33333333);
    step(1'b1, 6, 1'b1, "R5");
    check_bit(out_data === 32'h0F0F0F0F, "R3", "div8 word", out_data, 32'h0F0F0F0F);
    step(1'b1, 7, 1'b1, "R5");
    check_bit(out_data === 32'h000FFFFF, "R3", "div40 word0", out_data, 32'h000FFFFF);
    step(1'b1, 7, 1'b1, "R3");
    check_bit(out_data === 32'h0FFFFF00, "R3", "div40 word1", out_data, 32'h0FFFFF00);
    step(1'b1, 7, 1'b1, "R3");
    check_bit(out_data === 32'hFFFF0000, "R3", "div40 word2", out_data, 32'hFFFF0000);
    for (int i = 0; i < 30; i++) step(1'b1, 7, 1'b1, "R3");

    // R2 / R7: every source with toggling ready
    for (int s = 0; s < 8; s++) begin
      for (int i = 0; i < 60; i++) step(1'b1, s, (i % 3) != 1, "R7");
    end
    for (int i = 0; i < 40; i++) step(1'b1, 3, 1'b1, "R2");
    for (int i = 0; i < 40; i++) step(1'b1, 1, (i % 5) < 2, "R2");

    // R10: drop and raise enable with same code
    for (int i = 0; i < 3; i++) step(1'b0, 1, 1'b1, "R6");
    step(1'b1, 1, 1'b1, "R10");
    for (int i = 0; i < 10; i++) step(1'b1, 1, 1'b1, "R10");

    // R5: select change while stalled
    step(1'b1, 1, 1'b0, "R7");
    step(1'b1, 2, 1'b0, "R5");
    for (int i = 0; i < 10; i++) step(1'b1, 2, 1'b1, "R5");
    // R9: long PRBS31 run
    for (int i = 0; i < 50; i++) step(1'b1, 3, 1'b1, "R9");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule